// File: doc/BRIEF.md
# Odd-Invert Coupling-Aware Link Codec

This block sits in a network interface at both ends of an inter-router link of `W` wires. The transmit side accepts a payload flit of `W-1` bits with a valid strobe. It compares that flit with the last word it placed on the link, then sends the payload either unchanged or with its odd-indexed bits complemented. The choice is made to lower crosstalk energy between neighbouring wires. The top wire carries a flag that tells the receive side which form was sent. The receive side undoes the complement whenever the flag is set, so routers in between never need to know that coding is in use.

The decision is not a Hamming-distance count. For every pair of adjacent wires, the encoder classifies the transition from the previous word to the new one, weighting an opposite-direction toggle at 4, a lone toggle at 1, and a same-direction toggle or no change at 0. A pair votes for complementing when complementing makes its weighted cost strictly lower. Once more than half of the `W-1` pairs vote that way, the complemented form is sent. The encoder output is registered, and the decoder is purely combinational.

Top module: `oic_codec`

## Requirements
- R1: The link word holds the flag in bit W-1 and the payload in bits W-2..0. A flag of 1 means every odd-indexed payload bit (index 1, 3, 5, ...) was complemented; a flag of 0 means the payload is sent unchanged.
- R2: After reset, `tx_link` is all zeros, and this zero word is the comparison base for the first flit.
- R3: On a cycle where `tx_valid` is low, `tx_link` keeps its value and the comparison base does not change.
- R4: A flit presented with `tx_valid` high is taken at a rising clock edge, and its link word appears on `tx_link` just after that edge, never before it.
- R5: Each adjacent pair of wires (i, i+1), for i from 0 to W-2 of the full W-bit word, is costed from its previous value to its candidate value. An opposite-direction double toggle costs 4, a single toggle costs 1, and a same-direction double toggle or no change costs 0.
- R6: A pair votes to complement only when its cost towards the complemented candidate (odd payload bits flipped, flag 1) is strictly below its cost towards the plain candidate (payload unchanged, flag 0). A tie does not vote.
- R7: The complemented form is sent exactly when twice the number of voting pairs exceeds W-1 (for W=32, at least 16 of 31 pairs); otherwise the plain form is sent.
- R8: Even-indexed payload bits always reach the link unchanged.
- R9: The decoder returns the original payload from a link word: it complements the odd-indexed bits when bit W-1 is 1 and passes them through otherwise, with no clock delay.
- R10: The comparison base is the previous link word as sent, flag included, and not the previous raw payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_valid | input | 1 | Payload on `tx_payload` is to be sent this cycle |
| tx_payload | input | W-1 | Payload flit to encode |
| tx_link | output | W | Registered link word driven onto the wires |
| rx_link | input | W | Link word received from the wires |
| rx_payload | output | W-1 | Decoded payload, combinational from `rx_link` |

## Verification
The assertions check four things on every cycle: the link holds while idle, each sent word decodes back to the flit accepted one edge earlier, even payload bits never change, and the flag agrees with the vote count made at the accepting edge. Only the bench's scenarios can show that the vote itself is correct, that is, that the pair costing with its 4/1/0 weights, the strict-improvement rule and the majority threshold choose the right word for each history. The bench does this with a behavioural model fed by directed odd-bit patterns, counting, walking and random streams with idle gaps. It also checks the reset base and the one-edge latency.

// File: rtl/oic_pkg.sv
package oic_pkg;

    // Coupling classes for one adjacent wire pair
    typedef enum logic [1:0] {
        CPL_QUIET  = 2'd0,   // neither wire moves
        CPL_SINGLE = 2'd1,   // exactly one wire moves
        CPL_OPPOSE = 2'd2,   // both move, opposite directions
        CPL_ALIGN  = 2'd3    // both move, same direction
    } cpl_kind_e;

    function automatic cpl_kind_e classify_pair(
        input logic lo_old, input logic hi_old,
        input logic lo_new, input logic hi_new);
        logic lo_t, hi_t;
        lo_t = lo_old ^ lo_new;
        hi_t = hi_old ^ hi_new;
        if (lo_t && hi_t)
            return (lo_new != hi_new) ? CPL_OPPOSE : CPL_ALIGN;
        else if (lo_t || hi_t)
            return CPL_SINGLE;
        else
            return CPL_QUIET;
    endfunction

    function automatic logic [2:0] kind_weight(input cpl_kind_e k);
        case (k)
            CPL_OPPOSE: return 3'd4;
            CPL_SINGLE: return 3'd1;
            default:    return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/oic_pair_detect.sv
module oic_pair_detect
    import oic_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] prev_word,
    input  logic [W-1:0] plain_word,
    input  logic [W-1:0] flip_word,
    output logic [W-2:0] pair_vote
);
    localparam int NPAIR = W - 1;

    for (genvar i = 0; i < NPAIR; i++) begin : g_pair
        cpl_kind_e  kind_plain, kind_flip;
        logic [2:0] cost_plain, cost_flip;

        always_comb begin
            kind_plain = classify_pair(prev_word[i], prev_word[i+1],
                                       plain_word[i], plain_word[i+1]);
            kind_flip  = classify_pair(prev_word[i], prev_word[i+1],
                                       flip_word[i], flip_word[i+1]);
            cost_plain = kind_weight(kind_plain);
            cost_flip  = kind_weight(kind_flip);
            // strict improvement only; ties do not vote
            pair_vote[i] = (cost_flip < cost_plain);
        end
    end
endmodule

// File: rtl/oic_vote.sv
module oic_vote #(
    parameter int N = 31,
    localparam int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  hits,
    output logic [CW-1:0] count,
    output logic          majority
);
    always_comb begin
        count = '0;
        for (int i = 0; i < N; i++)
            count = count + CW'(hits[i]);
        majority = (2 * int'(count)) > N;
    end
endmodule

// File: rtl/oic_encoder.sv
module oic_encoder #(
    parameter int W = 32,
    localparam int P = W - 1,
    localparam int CW = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [P-1:0] in_data,
    output logic [W-1:0] link_q
);
    function automatic logic [W-1:0] flip_mask();
        logic [W-1:0] m;
        for (int i = 0; i < W; i++)
            m[i] = (i == W - 1) ? 1'b1 : i[0];
        return m;
    endfunction

    localparam logic [W-1:0] FLIP_MASK = flip_mask();
    localparam logic [P-1:0] ODD_MASK  = FLIP_MASK[P-1:0];

    typedef struct packed {
        logic [W-1:0] link;
    } enc_state_t;

    enc_state_t   st_d, st_q;
    logic [W-1:0] plain_w, flip_w;
    logic [P-1:0] votes;
    logic [CW-1:0] vote_cnt;
    logic          do_flip;

    assign plain_w = {1'b0, in_data};
    assign flip_w  = plain_w ^ FLIP_MASK;

    oic_pair_detect #(.W(W)) i_detect (
        .prev_word (st_q.link),
        .plain_word(plain_w),
        .flip_word (flip_w),
        .pair_vote (votes)
    );

    oic_vote #(.N(P)) i_vote (
        .hits    (votes),
        .count   (vote_cnt),
        .majority(do_flip)
    );

    always_comb begin
        st_d = st_q;
        if (in_valid)
            st_d.link = do_flip ? flip_w : plain_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign link_q = st_q.link;

    // Assertions
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(link_q));

    p_roundtrip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((link_q[P-1:0] ^ (link_q[W-1] ? ODD_MASK : '0))
                      == $past(in_data)));

    p_even_untouched_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((link_q[P-1:0] & ~ODD_MASK) == ($past(in_data) & ~ODD_MASK)));

    p_flag_follows_vote_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (link_q[W-1] == ((2 * int'($past(vote_cnt))) > P)));
endmodule

// File: rtl/oic_decoder.sv
module oic_decoder #(
    parameter int W = 32,
    localparam int P = W - 1
) (
    input  logic [W-1:0] link_in,
    output logic [P-1:0] data_out
);
    function automatic logic [P-1:0] odd_mask();
        logic [P-1:0] m;
        for (int i = 0; i < P; i++)
            m[i] = i[0];
        return m;
    endfunction

    localparam logic [P-1:0] ODD_MASK = odd_mask();

    always_comb begin
        data_out = link_in[P-1:0] ^ (link_in[W-1] ? ODD_MASK : '0);
        p_even_pass_r8: assert ((data_out & ~ODD_MASK) == (link_in[P-1:0] & ~ODD_MASK));
    end
endmodule

// File: rtl/oic_codec.sv
module oic_codec #(
    parameter int W = 32,
    localparam int P = W - 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tx_valid,
    input  logic [P-1:0] tx_payload,
    output logic [W-1:0] tx_link,
    input  logic [W-1:0] rx_link,
    output logic [P-1:0] rx_payload
);
    oic_encoder #(.W(W)) i_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(tx_valid),
        .in_data (tx_payload),
        .link_q  (tx_link)
    );

    oic_decoder #(.W(W)) i_dec (
        .link_in (rx_link),
        .data_out(rx_payload)
    );
endmodule

// File: tb/test_oic_codec.sv
module test_oic_codec;
    localparam int W = 32;
    localparam int P = W - 1;
    localparam time PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tx_valid = 1'b0;
    logic [P-1:0] tx_payload = '0;
    logic [W-1:0] tx_link;
    logic [W-1:0] rx_link;
    logic [P-1:0] rx_payload;

    int total = 0;
    int bad = 0;
    logic [W-1:0] m_prev = '0;

    always #(PERIOD/2) clk = ~clk;
    assign rx_link = tx_link;

    oic_codec #(.W(W)) i_oic_codec (
        .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_payload(tx_payload),
        .tx_link(tx_link), .rx_link(rx_link), .rx_payload(rx_payload)
    );

    function automatic int pair_cost(logic a0, logic b0, logic a1, logic b1);
        if ((a0 != a1) && (b0 != b1)) return (a1 != b1) ? 4 : 0;
        if ((a0 != a1) || (b0 != b1)) return 1;
        return 0;
    endfunction

    // behavioural reference for the word sent after a given history
    function automatic logic [W-1:0] ref_word(logic [W-1:0] prev, logic [P-1:0] d);
        logic [W-1:0] plain, flip;
        int wins = 0;
        plain = {1'b0, d};
        flip = plain;
        for (int i = 1; i < P; i += 2) flip[i] = ~flip[i];
        flip[W-1] = 1'b1;
        for (int i = 0; i < W - 1; i++) begin
            if (pair_cost(prev[i], prev[i+1], flip[i], flip[i+1]) <
                pair_cost(prev[i], prev[i+1], plain[i], plain[i+1]))
                wins++;
        end
        return (2 * wins > W - 1) ? flip : plain;
    endfunction

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic v, input logic [P-1:0] d);
        logic [W-1:0] exp;
        logic [P-1:0] evn;
        @(negedge clk);
        tx_valid = v;
        tx_payload = d;
        exp = v ? ref_word(m_prev, d) : m_prev;
        #1;
        check(tx_link == m_prev, "R4 no change before edge", tx_link, m_prev);
        @(posedge clk);
        m_prev = exp;
        #(PERIOD/4);
        if (v) begin
            check(tx_link == exp, "R5 R6 R7 R10 link word", tx_link, exp);
            check(rx_payload == d, "R9 R1 decoded payload", {1'b0, rx_payload}, {1'b0, d});
            for (int i = 0; i < P; i++) evn[i] = ~i[0];
            check((tx_link[P-1:0] & evn) == (d & evn), "R8 even bits",
                  {1'b0, tx_link[P-1:0] & evn}, {1'b0, d & evn});
        end else begin
            check(tx_link == exp, "R3 idle hold", tx_link, exp);
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [P-1:0] oddpat;
        logic [P-1:0] acc;
        for (int i = 0; i < P; i++) oddpat[i] = i[0];

        #(PERIOD * 3);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(tx_link == '0, "R2 reset link", tx_link, '0);
        check(rx_payload == '0, "R2 R9 reset decode", {1'b0, rx_payload}, '0);

        // R7 directed: odd-only pattern from zero base must be complemented
        send(1'b1, oddpat);
        check(tx_link == {1'b1, {P{1'b0}}}, "R7 R1 directed odd pattern",
              tx_link, {1'b1, {P{1'b0}}});
        // R10: same pattern again, base includes flag=1, stays complemented
        send(1'b1, oddpat);
        check(tx_link == {1'b1, {P{1'b0}}}, "R10 repeat with flag base",
              tx_link, {1'b1, {P{1'b0}}});
        // R3: idle cycles
        send(1'b0, '1);
        send(1'b0, '0);
        // all zeros after a complemented word
        send(1'b1, '0);
        send(1'b1, '1);
        send(1'b1, ~oddpat);
        // counting stream (correlated)
        for (int k = 0; k < 300; k++) send(1'b1, P'(k));
        // walking one
        for (int k = 0; k < P; k++) send(1'b1, P'(1) << k);
        // gray-coded stream
        for (int k = 0; k < 200; k++) send(1'b1, P'(k ^ (k >> 1)));
        // random with idle gaps
        for (int k = 0; k < 3000; k++) begin
            acc = P'($urandom);
            send(($urandom % 4) != 0, acc);
        end
        // random walk: few bits change per flit
        acc = '0;
        for (int k = 0; k < 1000; k++) begin
            acc[$urandom % P] ^= 1'b1;
            send(1'b1, acc);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule